// File: doc/BRIEF.md
# Pretrigger/Posttrigger Acquisition Sequencer

This block runs the horizontal side of a sampling acquisition. The processor holds an init line while it sets up the run. Once the line is released, the block counts sample points in a pretrigger phase. When enough points have been taken, it raises an arm flag towards the trigger logic. The first trigger taken while the flag is up becomes the main accepted trigger. That trigger starts a posttrigger count, and the sampler is stopped when the count runs out. A holdoff counter is loaded on every accepted trigger and blocks later triggers until it reaches zero. The holdoff carries over into the next acquisition.

A mode is latched when each run starts. In slow mode every point is written as it arrives into a circular acquisition store. In peak-detect mode the raw values inside one sample interval are reduced to a minimum and a maximum, and the pair is stored as one point. In fast mode the sampler keeps the record itself: the block counts points but writes nothing while running. After the stop it takes the digitized readout and stores it from address 0 upward. A CPU read port reaches the store, and it returns data only while the sequencer is idle. The store is `2**ADDR_W` bytes: 8192 when ADDR_W is 13, and 1024 in the default build.

Top module: `acq_sequencer`

## Requirements
- R1: While `init_hold` is high the block is idle (`sampler_run`=0, `done`=0) and points are not counted. A falling edge of `init_hold` starts a run: `sampler_run` is 1 in the following cycle, and counting starts from zero.
- R2: `eptho` is 1 only in the pretrigger phase, and only once the number of points counted there reaches `pre_count`. With `pre_count`=0 it is 1 as soon as the run starts.
- R3: A trigger while `eptho` is 0 is ignored: no `mat_pulse`, and the run stays in pretrigger.
- R4: An accepted trigger gives a one-cycle `mat_pulse` in the cycle after the accepting edge. It latches `trig_addr`, which is the write address of the first posttrigger point in slow and peak-detect modes, and `pre_count` in fast mode. After `post_count` further points `sampler_run` drops.
- R5: `done` goes to 1 when the record is complete and is cleared by the next `init_hold`.
- R6: In slow mode (`mode`=0) point k of a run (counting from 0) is written at address k modulo `2**ADDR_W`.
- R7: In peak-detect mode (`mode`=2) a point closes on `sample_valid` with `interval_end` high. The minimum of the interval, closing sample included, goes to an even address and the maximum to the next odd address. The write address advances by 2 for each point.
- R8: In fast mode (`mode`=1) nothing is written while the sampler runs. After the stop, the next `pre_count+post_count` values on `sample_valid` are written at addresses 0, 1, 2 and onward. `done` is set only after the last of them.
- R9: After an accepted trigger with holdoff length L, the next trigger is accepted no sooner than L+1 clock edges later, even if a new run has started in between.
- R10: A CPU read issued while idle returns `mem[cpu_addr]` with `cpu_rd_valid`=1 one cycle later. A read issued during a run returns `cpu_rd_valid`=0 and data 0.
- R11: Raising `init_hold` in the middle of a run stops the sampler at the next edge, without setting `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_hold | input | 1 | Processor init line; release starts a run |
| mode | input | 2 | 0 slow, 1 fast, 2 peak-detect (3 acts as slow) |
| pre_count | input | CNT_W | Pretrigger points required before arming |
| post_count | input | CNT_W | Posttrigger points before stop |
| holdoff_len | input | HOLD_W | Trigger holdoff length in clock cycles |
| sample_valid | input | 1 | A sample value is present this cycle |
| interval_end | input | 1 | Closes a peak-detect interval with this sample |
| sample_data | input | 8 | Sample value |
| trig_in | input | 1 | Trigger from the trigger logic |
| eptho | output | 1 | Pretrigger satisfied; triggers may be accepted |
| mat_pulse | output | 1 | One cycle after a main accepted trigger |
| sampler_run | output | 1 | Sampler is acquiring |
| done | output | 1 | Record complete |
| holdoff_busy | output | 1 | Holdoff window is open |
| trig_addr | output | ADDR_W | Latched trigger position in the store |
| cpu_rd_en | input | 1 | CPU read request |
| cpu_addr | input | ADDR_W | CPU read address |
| cpu_rd_data | output | 8 | CPU read data |
| cpu_rd_valid | output | 1 | CPU read data valid |

## Verification
The assertions take for granted that `mode`, `pre_count`, `post_count` and `holdoff_len` stay constant while a run is in progress. They also assume that the peak-detect write address starts even, which holds because every run resets it to zero. The stimulus changes those settings only while `init_hold` is high. It spaces sample points at least one idle cycle apart and never drives a trigger in the same cycle as a point, so each pretrigger and posttrigger count follows one known sequence.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int SMP_W = 8;

    typedef enum logic [1:0] {
        MODE_SLOW = 2'd0,
        MODE_FAST = 2'd1,
        MODE_PEAK = 2'd2,
        MODE_RSVD = 2'd3
    } acq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_XFER = 2'd3
    } acq_state_e;

    typedef struct packed {
        logic [SMP_W-1:0] lo;
        logic [SMP_W-1:0] hi;
    } smp_pair_t;

    function automatic logic [SMP_W-1:0] smp_min(input logic [SMP_W-1:0] a, input logic [SMP_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [SMP_W-1:0] smp_max(input logic [SMP_W-1:0] a, input logic [SMP_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_hold,
    input  acq_mode_e         mode,
    input  logic [CNT_W-1:0]  pre_count,
    input  logic [CNT_W-1:0]  post_count,
    input  logic [HOLD_W-1:0] holdoff_len,
    input  logic              sample_valid,
    input  logic              interval_end,
    input  logic              trig_in,
    output acq_state_e        state,
    output logic              wr_en,
    output logic              wr_pair,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              peak_run,
    output logic              eptho,
    output logic              mat_pulse,
    output logic              run,
    output logic              done,
    output logic              holdoff_busy,
    output logic [ADDR_W-1:0] trig_addr
);

    localparam int LEN_W = CNT_W + 1;

    acq_state_e        state_q;
    acq_mode_e         mode_q;
    logic              init_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  pre_cnt_q;
    logic [CNT_W-1:0]  post_cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic [LEN_W-1:0]  xfer_q;
    logic [ADDR_W-1:0] trig_q;
    logic              done_q;
    logic              mat_q;

    logic              start;
    logic              pre_met;
    logic              accept;
    logic              post_end;
    logic              xfer_end;
    logic              point;
    logic              point_taken;
    logic [LEN_W-1:0]  rec_len;
    logic [ADDR_W-1:0] ptr_step;

    always_comb begin
        start       = (state_q == ST_IDLE) && init_q && !init_hold;
        pre_met     = pre_cnt_q >= pre_count;
        eptho       = (state_q == ST_PRE) && pre_met;
        holdoff_busy = hold_q != '0;
        accept      = eptho && trig_in && !holdoff_busy && !init_hold;
        post_end    = post_cnt_q >= post_count;
        rec_len     = {1'b0, pre_count} + {1'b0, post_count};
        xfer_end    = xfer_q >= rec_len;
        peak_run    = (mode_q == MODE_PEAK) && ((state_q == ST_PRE) || (state_q == ST_POST));
        point       = sample_valid && (peak_run ? interval_end : 1'b1);
        point_taken = point && ((state_q == ST_PRE) || ((state_q == ST_POST) && !post_end));
        ptr_step    = (mode_q == MODE_PEAK) ? ADDR_W'(2) : ADDR_W'(1);
        wr_pair     = point_taken && (mode_q == MODE_PEAK);
        wr_en       = (point_taken && (mode_q != MODE_FAST))
                    || ((state_q == ST_XFER) && !xfer_end && sample_valid);
        wr_addr     = (state_q == ST_XFER) ? xfer_q[ADDR_W-1:0] : ptr_q;
        run         = (state_q == ST_PRE) || (state_q == ST_POST);
    end

    assign state     = state_q;
    assign done      = done_q;
    assign mat_pulse = mat_q;
    assign trig_addr = trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            mode_q     <= MODE_SLOW;
            init_q     <= 1'b0;
            ptr_q      <= '0;
            pre_cnt_q  <= '0;
            post_cnt_q <= '0;
            hold_q     <= '0;
            xfer_q     <= '0;
            trig_q     <= '0;
            done_q     <= 1'b0;
            mat_q      <= 1'b0;
        end else begin
            init_q <= init_hold;
            mat_q  <= accept;
            if (accept) begin
                hold_q <= holdoff_len;
            end else if (holdoff_busy) begin
                hold_q <= hold_q - HOLD_W'(1);
            end

            if (init_hold) begin
                state_q    <= ST_IDLE;
                done_q     <= 1'b0;
                ptr_q      <= '0;
                pre_cnt_q  <= '0;
                post_cnt_q <= '0;
                xfer_q     <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (start) begin
                            state_q <= ST_PRE;
                            mode_q  <= mode;
                        end
                    end
                    ST_PRE: begin
                        if (point) begin
                            ptr_q <= ptr_q + ptr_step;
                            if (!pre_met) begin
                                pre_cnt_q <= pre_cnt_q + CNT_W'(1);
                            end
                        end
                        if (accept) begin
                            state_q    <= ST_POST;
                            trig_q     <= (mode_q == MODE_FAST) ? pre_count[ADDR_W-1:0] : ptr_q;
                            post_cnt_q <= point ? CNT_W'(1) : '0;
                        end
                    end
                    ST_POST: begin
                        if (post_end) begin
                            if (mode_q == MODE_FAST) begin
                                state_q <= ST_XFER;
                            end else begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                        end else if (point) begin
                            ptr_q      <= ptr_q + ptr_step;
                            post_cnt_q <= post_cnt_q + CNT_W'(1);
                        end
                    end
                    ST_XFER: begin
                        if (xfer_end) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else if (sample_valid) begin
                            xfer_q <= xfer_q + LEN_W'(1);
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_INIT_FORCES_IDLE: assert property (@(posedge clk) disable iff (rst)
        init_hold |=> (state_q == ST_IDLE) && !done_q && !run); // R1

    AST_NO_TRIG_UNARMED: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PRE) && !eptho) |=> (state_q != ST_POST)); // R3

    AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PRE) && holdoff_busy) |=> (state_q != ST_POST)); // R9

    AST_POST_STOPS: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_POST) && post_end) |=> !run); // R4

    AST_DONE_AFTER_RECORD: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (($past(state_q) == ST_POST) || ($past(state_q) == ST_XFER))); // R5

    AST_FAST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (run && (mode_q == MODE_FAST)) |-> !wr_en); // R8

endmodule

// File: rtl/acq_peak.sv
module acq_peak
    import acq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             last,
    input  logic [SMP_W-1:0] data,
    output smp_pair_t        pair_o
);

    logic             fresh_q;
    logic [SMP_W-1:0] lo_q;
    logic [SMP_W-1:0] hi_q;

    always_comb begin
        pair_o.lo = fresh_q ? data : smp_min(lo_q, data);
        pair_o.hi = fresh_q ? data : smp_max(hi_q, data);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fresh_q <= 1'b1;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (en) begin
            if (last) begin
                fresh_q <= 1'b1;
            end else begin
                fresh_q <= 1'b0;
                lo_q    <= pair_o.lo;
                hi_q    <= pair_o.hi;
            end
        end
    end

    AST_PEAK_ORDER: assert property (@(posedge clk) disable iff (rst)
        !fresh_q |-> (lo_q <= hi_q)); // R7

endmodule

// File: rtl/acq_mem.sv
module acq_mem
    import acq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              pair,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [SMP_W-1:0]  d_lo,
    input  logic [SMP_W-1:0]  d_hi,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [SMP_W-1:0]  rdata,
    output logic              rvalid
);

    localparam int ROWS  = 2 ** (ADDR_W - 1);
    localparam int ROW_W = ADDR_W - 1;

    logic [ROW_W-1:0] wrow;
    logic [ROW_W-1:0] rrow;
    logic [SMP_W-1:0] bank_q [2];
    logic             rsel_q;
    logic             rvalid_q;

    assign wrow = waddr[ADDR_W-1:1];
    assign rrow = raddr[ADDR_W-1:1];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [SMP_W-1:0] cells [ROWS];
        logic [SMP_W-1:0] rd_q;
        logic             hit;
        logic [SMP_W-1:0] wdat;

        assign hit  = we && (pair || (waddr[0] == 1'(b)));
        assign wdat = (pair && (b == 1)) ? d_hi : d_lo;

        always_ff @(posedge clk) begin
            if (hit) begin
                cells[wrow] <= wdat;
            end
            rd_q <= cells[rrow];
        end

        assign bank_q[b] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsel_q   <= 1'b0;
            rvalid_q <= 1'b0;
        end else begin
            rsel_q   <= raddr[0];
            rvalid_q <= re;
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = rvalid_q ? bank_q[rsel_q] : '0;

    AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (rst)
        (we && pair) |-> !waddr[0]); // R7

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_hold,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  pre_count,
    input  logic [CNT_W-1:0]  post_count,
    input  logic [HOLD_W-1:0] holdoff_len,
    input  logic              sample_valid,
    input  logic              interval_end,
    input  logic [7:0]        sample_data,
    input  logic              trig_in,
    output logic              eptho,
    output logic              mat_pulse,
    output logic              sampler_run,
    output logic              done,
    output logic              holdoff_busy,
    output logic [ADDR_W-1:0] trig_addr,
    input  logic              cpu_rd_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [7:0]        cpu_rd_data,
    output logic              cpu_rd_valid
);

    acq_state_e        state;
    logic              wr_en;
    logic              wr_pair;
    logic [ADDR_W-1:0] wr_addr;
    logic              peak_run;
    smp_pair_t         peak;
    logic [7:0]        wr_lo;

    acq_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .HOLD_W (HOLD_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .init_hold    (init_hold),
        .mode         (acq_mode_e'(mode)),
        .pre_count    (pre_count),
        .post_count   (post_count),
        .holdoff_len  (holdoff_len),
        .sample_valid (sample_valid),
        .interval_end (interval_end),
        .trig_in      (trig_in),
        .state        (state),
        .wr_en        (wr_en),
        .wr_pair      (wr_pair),
        .wr_addr      (wr_addr),
        .peak_run     (peak_run),
        .eptho        (eptho),
        .mat_pulse    (mat_pulse),
        .run          (sampler_run),
        .done         (done),
        .holdoff_busy (holdoff_busy),
        .trig_addr    (trig_addr)
    );

    acq_peak u_peak (
        .clk    (clk),
        .rst    (rst),
        .clr    (state == ST_IDLE),
        .en     (sample_valid && peak_run),
        .last   (interval_end),
        .data   (sample_data),
        .pair_o (peak)
    );

    assign wr_lo = wr_pair ? peak.lo : sample_data;

    acq_mem #(
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en),
        .pair   (wr_pair),
        .waddr  (wr_addr),
        .d_lo   (wr_lo),
        .d_hi   (peak.hi),
        .re     (cpu_rd_en && (state == ST_IDLE)),
        .raddr  (cpu_addr),
        .rdata  (cpu_rd_data),
        .rvalid (cpu_rd_valid)
    );

    AST_RD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_valid |-> ($past(state) == ST_IDLE)); // R10

endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = 16;
    localparam int HOLD_W = 12;
    localparam int DEPTH  = 2 ** ADDR_W;
    localparam int WATCHDOG = 150000;

    // {pre_count, extra pretrigger points, post_count, expected trig_addr}
    localparam logic [63:0] TBL [4] = '{
        {16'd4,    16'd0,  16'd3, 16'd4},
        {16'd0,    16'd0,  16'd0, 16'd0},
        {16'd2,    16'd5,  16'd4, 16'd7},
        {16'd1000, 16'd30, 16'd5, 16'd6}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              init_hold = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [CNT_W-1:0]  pre_count = '0;
    logic [CNT_W-1:0]  post_count = '0;
    logic [HOLD_W-1:0] holdoff_len = '0;
    logic              sample_valid = 1'b0;
    logic              interval_end = 1'b0;
    logic [7:0]        sample_data = '0;
    logic              trig_in = 1'b0;
    logic              eptho, mat_pulse, sampler_run, done, holdoff_busy;
    logic [ADDR_W-1:0] trig_addr;
    logic              cpu_rd_en = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [7:0]        cpu_rd_data;
    logic              cpu_rd_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    acq_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_dut (
        .clk(clk), .rst(rst), .init_hold(init_hold), .mode(mode),
        .pre_count(pre_count), .post_count(post_count), .holdoff_len(holdoff_len),
        .sample_valid(sample_valid), .interval_end(interval_end), .sample_data(sample_data),
        .trig_in(trig_in), .eptho(eptho), .mat_pulse(mat_pulse), .sampler_run(sampler_run),
        .done(done), .holdoff_busy(holdoff_busy), .trig_addr(trig_addr),
        .cpu_rd_en(cpu_rd_en), .cpu_addr(cpu_addr), .cpu_rd_data(cpu_rd_data),
        .cpu_rd_valid(cpu_rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 7 + 3) % 256);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic start_acq();
        init_hold = 1'b1;
        step();
        step();
        init_hold = 1'b0;
        step();
    endtask

    task automatic pt(input logic [7:0] d, input logic iend);
        sample_valid = 1'b1;
        sample_data  = d;
        interval_end = iend;
        step();
        sample_valid = 1'b0;
        interval_end = 1'b0;
        step();
    endtask

    task automatic trig();
        trig_in = 1'b1;
        step();
        trig_in = 1'b0;
    endtask

    task automatic cpu_read(input int a, output logic [7:0] d, output logic v);
        cpu_rd_en = 1'b1;
        cpu_addr  = ADDR_W'(a);
        step();
        d = cpu_rd_data;
        v = cpu_rd_valid;
        cpu_rd_en = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        logic       rv;
        int         k;
        int         a_cyc;
        int         waited;

        // reset state
        step();
        step();
        chk("R1", "reset sampler_run", 32'(sampler_run), 0);
        chk("R2", "reset eptho", 32'(eptho), 0);
        chk("R5", "reset done", 32'(done), 0);
        chk("R4", "reset mat_pulse", 32'(mat_pulse), 0);
        chk("R10", "reset cpu_rd_valid", 32'(cpu_rd_valid), 0);
        rst = 1'b0;
        step();

        // table walk: slow-mode records
        foreach (TBL[i]) begin
            int pre;
            int extra;
            int post;
            int exp_t;
            pre   = int'(TBL[i][63:48]);
            extra = int'(TBL[i][47:32]);
            post  = int'(TBL[i][31:16]);
            exp_t = int'(TBL[i][15:0]);
            mode = 2'd0;
            pre_count   = CNT_W'(pre);
            post_count  = CNT_W'(post);
            holdoff_len = '0;
            start_acq();
            chk("R1", "run after release", 32'(sampler_run), 1);
            chk("R5", "done cleared by init", 32'(done), 0);
            if (pre == 0) chk("R2", "eptho with zero pre_count", 32'(eptho), 1);
            k = 0;
            for (int j = 0; j < pre + extra; j++) begin
                if (pre > 0 && j == pre - 1) begin
                    chk("R2", "eptho one point short", 32'(eptho), 0);
                    trig();
                    chk("R3", "trigger ignored before eptho", 32'(mat_pulse), 0);
                end
                pt(pat(k), 1'b0);
                k++;
                if (j == pre - 1) chk("R2", "eptho at pre_count", 32'(eptho), 1);
            end
            trig();
            chk("R4", "mat_pulse on accept", 32'(mat_pulse), 1);
            chk("R4", "trig_addr slow", 32'(trig_addr), 32'(exp_t));
            for (int j = 0; j < post; j++) begin
                pt(pat(k), 1'b0);
                k++;
            end
            step();
            chk("R4", "sampler stopped", 32'(sampler_run), 0);
            chk("R5", "done after record", 32'(done), 1);
            if (post > 0) begin
                cpu_read(exp_t, rd, rv);
                chk("R6", "data at trigger address", 32'(rd), 32'(pat(pre + extra)));
                chk("R10", "read valid when idle", 32'(rv), 1);
            end
            if (pre + extra > 0) begin
                cpu_read((exp_t + DEPTH - 1) % DEPTH, rd, rv);
                chk("R6", "data before trigger (circular)", 32'(rd), 32'(pat(pre + extra - 1)));
            end
        end

        // R1: points while init held are not counted
        mode = 2'd0;
        pre_count = CNT_W'(1);
        post_count = CNT_W'(1);
        init_hold = 1'b1;
        step();
        pt(8'h11, 1'b0);
        chk("R1", "no run while init held", 32'(sampler_run), 0);
        chk("R1", "no eptho while init held", 32'(eptho), 0);
        init_hold = 1'b0;
        step();
        chk("R1", "run after release", 32'(sampler_run), 1);
        chk("R1", "held points not counted", 32'(eptho), 0);
        pt(8'h12, 1'b0);
        chk("R2", "eptho after first counted point", 32'(eptho), 1);

        // R11: abort mid-run
        init_hold = 1'b1;
        step();
        chk("R11", "abort stops sampler", 32'(sampler_run), 0);
        chk("R11", "abort leaves done low", 32'(done), 0);
        chk("R11", "abort drops eptho", 32'(eptho), 0);

        // R8: fast mode
        mode = 2'd1;
        pre_count = CNT_W'(3);
        post_count = CNT_W'(2);
        start_acq();
        for (int j = 0; j < 6; j++) pt(8'hF0 + 8'(j), 1'b0);
        trig();
        chk("R4", "trig_addr fast is pre_count", 32'(trig_addr), 3);
        pt(8'hE0, 1'b0);
        pt(8'hE1, 1'b0);
        chk("R8", "sampler stopped before transfer", 32'(sampler_run), 0);
        chk("R8", "done waits for transfer", 32'(done), 0);
        for (int j = 0; j < 4; j++) pt(8'hA0 + 8'(j), 1'b0);
        chk("R8", "done low one value short", 32'(done), 0);
        pt(8'hA4, 1'b0);
        chk("R8", "done after full transfer", 32'(done), 1);
        for (int j = 0; j < 5; j++) begin
            cpu_read(j, rd, rv);
            chk("R8", "transfer data", 32'(rd), 32'(8'hA0 + 8'(j)));
        end
        for (int j = 5; j < 8; j++) begin
            cpu_read(j, rd, rv);
            chk("R8", "no write during fast run", 32'(rd), 32'(pat(1024 + j)));
        end

        // R7: peak-detect mode
        mode = 2'd2;
        pre_count = CNT_W'(2);
        post_count = CNT_W'(1);
        start_acq();
        pt(8'd30, 1'b0);
        pt(8'd10, 1'b0);
        pt(8'd50, 1'b1);
        chk("R2", "peak eptho after one interval", 32'(eptho), 0);
        cpu_read(0, rd, rv);
        chk("R10", "read during run not valid", 32'(rv), 0);
        chk("R10", "read during run data zero", 32'(rd), 0);
        pt(8'd200, 1'b0);
        pt(8'd90, 1'b1);
        chk("R2", "peak eptho after two intervals", 32'(eptho), 1);
        trig();
        chk("R7", "peak trig_addr", 32'(trig_addr), 4);
        pt(8'd7, 1'b1);
        step();
        chk("R5", "peak done", 32'(done), 1);
        cpu_read(0, rd, rv); chk("R7", "interval 0 min", 32'(rd), 10);
        cpu_read(1, rd, rv); chk("R7", "interval 0 max", 32'(rd), 50);
        cpu_read(2, rd, rv); chk("R7", "interval 1 min", 32'(rd), 90);
        cpu_read(3, rd, rv); chk("R7", "interval 1 max", 32'(rd), 200);
        cpu_read(4, rd, rv); chk("R7", "interval 2 min", 32'(rd), 7);
        cpu_read(5, rd, rv); chk("R7", "interval 2 max", 32'(rd), 7);

        // R9: holdoff spans into the next run
        mode = 2'd0;
        pre_count = '0;
        post_count = CNT_W'(1);
        holdoff_len = HOLD_W'(40);
        start_acq();
        trig();
        a_cyc = cyc;
        chk("R9", "first trigger accepted", 32'(mat_pulse), 1);
        pt(8'h33, 1'b0);
        start_acq();
        chk("R2", "eptho in new run", 32'(eptho), 1);
        trig_in = 1'b1;
        step();
        chk("R9", "trigger ignored during holdoff", 32'(mat_pulse), 0);
        chk("R9", "holdoff_busy during window", 32'(holdoff_busy), 1);
        waited = 0;
        while (!mat_pulse && waited < 200) begin
            step();
            waited++;
        end
        trig_in = 1'b0;
        chk("R9", "accept spacing L+1", 32'(cyc - a_cyc), 41);
        pt(8'h34, 1'b0);
        step();
        chk("R5", "done after holdoff run", 32'(done), 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule